// File: doc/BRIEF.md
# Floating-Point Condition and Conditional Branch Unit

This block keeps the 32-bit floating-point control/status word and, inside it, the single condition bit that floating-point compares produce and floating-point conditional branches consume. An external comparator supplies a one-bit predicate, a strobe saying a compare is issuing, and a flag saying the compare's format field was legal. On a legal compare the block replaces only the condition bit of the stored word; every other bit of the word is kept. A later pipeline stage may also be writing a whole new control word. That value is committed on the same edge, and it is forwarded at once to any branch being resolved in the same cycle.

For a branch, the block takes the instruction word and the branch's PC. In the same cycle it returns whether the branch is taken, the 64-bit target address, and whether the delay-slot instruction must be nullified. Branch outputs are combinational from the inputs and the stored word. The compare and control-word updates become visible on the clock edge that follows.

Top module: `fpcc_unit`

## Requirements
- R1: After a synchronous active-low reset, `ctl_word` reads 0x00000000.
- R2: When `cmp_valid` and `cmp_fmt_ok` are both high at a rising edge, bit 23 of `ctl_word` after that edge equals `cmp_flag`. Every other bit is taken unchanged from the word that would otherwise be stored.
- R3: A compare with `cmp_fmt_ok` low changes nothing. When neither a legal compare nor a control-word write is present, `ctl_word` holds its value.
- R4: When `wb_wr` is high at a rising edge, `ctl_word` after that edge equals `wb_data`. If a legal compare arrives in the same cycle, the result is `wb_data` with bit 23 replaced by `cmp_flag`.
- R5: The condition a branch tests is `wb_data[23]` while `wb_wr` is high, and the stored `ctl_word[23]` otherwise.
- R6: Instruction bits 17:16 pick the branch kind: 0 takes when the condition is 0, 1 takes when it is 1, 2 takes when it is 0 (likely form), and 3 takes when it is 1 (likely form). `br_taken` is high exactly when `br_valid` is high and the condition matches.
- R7: `br_target` equals `br_pc` + 4 + (sign-extended `br_instr[15:0]` shifted left by 2), computed modulo 2^64.
- R8: `br_nullify` is high exactly when `br_valid` is high, bit 17 of the instruction is 1 (likely form), and the branch is not taken. The plain forms never nullify.
- R9: While `br_valid` is low, `br_taken` and `br_nullify` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | A compare is issuing this cycle |
| cmp_fmt_ok | input | 1 | The compare's format is legal |
| cmp_flag | input | 1 | Predicate result from the external comparator |
| wb_wr | input | 1 | Later stage is writing the control word this cycle |
| wb_data | input | 32 | Value being written to the control word |
| br_valid | input | 1 | A conditional FP branch is being resolved |
| br_instr | input | 32 | Branch instruction word |
| br_pc | input | 64 | Address of the branch |
| br_taken | output | 1 | Branch is taken |
| br_target | output | 64 | Taken-path address |
| br_nullify | output | 1 | Squash the delay-slot instruction |
| ctl_word | output | 32 | Stored control/status word |

## Verification
Directed cases first try each of the four branch kinds against both condition values. This separates the polarity bit from the likely bit. A forwarding case holds a stored condition opposite to the value in flight, so it shows whether the branch reads the bypassed value or the stale one. Target cases use PCs near both ends of the address space with positive and negative offsets, which exposes a missing sign extension or a truncated carry. Random cycles then mix compares (legal and illegal), whole-word writes, and branches in every overlap. Because background bits in the word are random, a compare that disturbs any bit other than bit 23 is detected.

// File: rtl/fpcc_pkg.sv
// Shared types and defaults for the FP condition/branch unit.
package fpcc_pkg;

    localparam int unsigned CTL_W_DEF    = 32;
    localparam int unsigned COND_POS_DEF = 23;
    localparam int unsigned PC_W_DEF     = 64;

    // Branch kind encoded in instruction bits 17:16.
    // Bit 0 is the wanted condition value; bit 1 marks the likely form.
    typedef enum logic [1:0] {
        BK_ON_FALSE        = 2'd0,
        BK_ON_TRUE         = 2'd1,
        BK_ON_FALSE_LIKELY = 2'd2,
        BK_ON_TRUE_LIKELY  = 2'd3
    } branch_kind_e;

    typedef struct packed {
        logic taken;
        logic nullify;
    } branch_verdict_t;

endpackage

// File: rtl/fpcc_status_reg.sv
// fpcc_status_reg: stores the FP control/status word.
// A legal compare rewrites only the condition bit. A whole-word write
// from a later stage commits on the same edge and is also forwarded
// combinationally as the effective condition.
// Assumes: the compare is younger than the in-flight word write, so
// when both arrive together the compare's bit is applied on top.
module fpcc_status_reg #(
    parameter int unsigned        CTL_W      = 32,
    parameter int unsigned        COND_POS   = 23,
    parameter logic [CTL_W-1:0]   RESET_WORD = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic             cmp_fmt_ok,
    input  logic             cmp_flag,
    input  logic             wb_wr,
    input  logic [CTL_W-1:0] wb_data,
    output logic [CTL_W-1:0] word_q,
    output logic             cond_eff
);

    logic [CTL_W-1:0] base_word;
    logic [CTL_W-1:0] next_word;
    logic             cmp_apply;

    assign cmp_apply = cmp_valid && cmp_fmt_ok;

    // Pick the word that a compare would modify: bypassed or stored.
    always_comb begin
        base_word = wb_wr ? wb_data : word_q;
    end

    // Replace only the condition bit when a legal compare issues.
    always_comb begin
        next_word = base_word;
        if (cmp_apply) begin
            next_word[COND_POS] = cmp_flag;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= RESET_WORD;
        end else begin
            word_q <= next_word;
        end
    end

    // Condition seen by a branch this cycle, with forwarding.
    always_comb begin
        cond_eff = base_word[COND_POS];
    end

endmodule

// File: rtl/fpcc_branch_resolve.sv
// fpcc_branch_resolve: turns branch kind and condition into taken and
// delay-slot nullify. Assumes the kind field is already extracted.
module fpcc_branch_resolve
    import fpcc_pkg::*;
(
    input  logic            br_valid,
    input  logic [1:0]      kind_bits,
    input  logic            cond,
    output branch_verdict_t verdict
);

    branch_kind_e kind;
    logic         want;
    logic         likely;

    assign kind = branch_kind_e'(kind_bits);

    // Decode the kind into wanted polarity and likely flag.
    always_comb begin
        unique case (kind)
            BK_ON_FALSE:        begin want = 1'b0; likely = 1'b0; end
            BK_ON_TRUE:         begin want = 1'b1; likely = 1'b0; end
            BK_ON_FALSE_LIKELY: begin want = 1'b0; likely = 1'b1; end
            BK_ON_TRUE_LIKELY:  begin want = 1'b1; likely = 1'b1; end
            default:            begin want = 1'b0; likely = 1'b0; end
        endcase
    end

    // Form the verdict; an untaken likely branch squashes its slot.
    always_comb begin
        verdict.taken   = br_valid && (cond == want);
        verdict.nullify = br_valid && likely && (cond != want);
    end

endmodule

// File: rtl/fpcc_target_gen.sv
// fpcc_target_gen: branch target = pc + STEP + (sext(imm) << SHIFT),
// at PC_W bits with wraparound. Assumes PC_W > IMM_W + SHIFT.
module fpcc_target_gen #(
    parameter int unsigned PC_W  = 64,
    parameter int unsigned IMM_W = 16,
    parameter int unsigned SHIFT = 2,
    parameter int unsigned STEP  = 4
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [IMM_W-1:0] imm,
    output logic [PC_W-1:0]  target
);

    localparam int unsigned EXT_W = PC_W - IMM_W - SHIFT;

    logic [PC_W-1:0] offset;

    // Sign-extend and scale the immediate to a byte offset.
    always_comb begin
        offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
    end

    // Add the sequential step and the offset; carries out are dropped.
    always_comb begin
        target = pc + PC_W'(STEP) + offset;
    end

endmodule

// File: rtl/fpcc_unit.sv
// fpcc_unit: FP condition bit holder and conditional-branch resolver.
// Branch outputs are combinational. Word updates appear after the edge.
// Assumes the comparator itself lives outside and sends a 1-bit result.
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int unsigned CTL_W    = CTL_W_DEF,
    parameter int unsigned COND_POS = COND_POS_DEF,
    parameter int unsigned PC_W     = PC_W_DEF,
    parameter int unsigned INSTR_W  = 32,
    parameter int unsigned IMM_W    = 16,
    parameter int unsigned KIND_LSB = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_valid,
    input  logic               cmp_fmt_ok,
    input  logic               cmp_flag,
    input  logic               wb_wr,
    input  logic [CTL_W-1:0]   wb_data,
    input  logic               br_valid,
    input  logic [INSTR_W-1:0] br_instr,
    input  logic [PC_W-1:0]    br_pc,
    output logic               br_taken,
    output logic [PC_W-1:0]    br_target,
    output logic               br_nullify,
    output logic [CTL_W-1:0]   ctl_word
);

    logic            cond_eff;
    branch_verdict_t verdict;
    logic            unused_instr_bits;

    // Fields not used by this block.
    assign unused_instr_bits = ^{br_instr[INSTR_W-1:KIND_LSB+2],
                                 br_instr[KIND_LSB-1:IMM_W]};

    fpcc_status_reg #(
        .CTL_W      (CTL_W),
        .COND_POS   (COND_POS),
        .RESET_WORD ('0)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_valid  (cmp_valid),
        .cmp_fmt_ok (cmp_fmt_ok),
        .cmp_flag   (cmp_flag),
        .wb_wr      (wb_wr),
        .wb_data    (wb_data),
        .word_q     (ctl_word),
        .cond_eff   (cond_eff)
    );

    fpcc_branch_resolve u_resolve (
        .br_valid  (br_valid),
        .kind_bits (br_instr[KIND_LSB+1:KIND_LSB]),
        .cond      (cond_eff),
        .verdict   (verdict)
    );

    fpcc_target_gen #(
        .PC_W  (PC_W),
        .IMM_W (IMM_W),
        .SHIFT (2),
        .STEP  (4)
    ) u_target (
        .pc     (br_pc),
        .imm    (br_instr[IMM_W-1:0]),
        .target (br_target)
    );

    assign br_taken   = verdict.taken;
    assign br_nullify = verdict.nullify;

endmodule

// File: rtl/fpcc_unit_checker.sv
// fpcc_unit_checker: temporal properties of fpcc_unit, bound in below.
module fpcc_unit_checker #(
    parameter int unsigned CTL_W    = 32,
    parameter int unsigned COND_POS = 23,
    parameter int unsigned INSTR_W  = 32,
    parameter int unsigned KIND_LSB = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmp_valid,
    input logic               cmp_fmt_ok,
    input logic               cmp_flag,
    input logic               wb_wr,
    input logic [CTL_W-1:0]   wb_data,
    input logic               br_valid,
    input logic [INSTR_W-1:0] br_instr,
    input logic               br_taken,
    input logic               br_nullify,
    input logic [CTL_W-1:0]   ctl_word
);

    logic live_q;

    // Marks cycles that have a reset-free previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        $past(!rst_n) && live_q == 1'b0 && rst_n |-> ctl_word == '0);

    assert_cmp_sets_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && cmp_valid && cmp_fmt_ok |=> ctl_word[COND_POS] == $past(cmp_flag));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !wb_wr && !(cmp_valid && cmp_fmt_ok) |=> $stable(ctl_word));

    assert_wb_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && wb_wr && !cmp_valid |=> ctl_word == $past(wb_data));

    assert_plain_no_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !br_instr[KIND_LSB+1] |-> !br_nullify);

    assert_taken_excl_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_taken && br_nullify));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> !br_taken && !br_nullify);

endmodule

bind fpcc_unit fpcc_unit_checker #(
    .CTL_W    (CTL_W),
    .COND_POS (COND_POS),
    .INSTR_W  (INSTR_W),
    .KIND_LSB (KIND_LSB)
) u_fpcc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_valid  (cmp_valid),
    .cmp_fmt_ok (cmp_fmt_ok),
    .cmp_flag   (cmp_flag),
    .wb_wr      (wb_wr),
    .wb_data    (wb_data),
    .br_valid   (br_valid),
    .br_instr   (br_instr),
    .br_taken   (br_taken),
    .br_nullify (br_nullify),
    .ctl_word   (ctl_word)
);

// File: tb/fpcc_unit_test.sv
`timescale 1ns/1ps
module fpcc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmp_valid, cmp_fmt_ok, cmp_flag, wb_wr, br_valid;
    logic [31:0] wb_data, br_instr;
    logic [63:0] br_pc;
    logic        br_taken, br_nullify;
    logic [63:0] br_target;
    logic [31:0] ctl_word;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    logic [31:0] model;

    always #10 clk = ~clk;

    fpcc_unit uut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_fmt_ok(cmp_fmt_ok),
        .cmp_flag(cmp_flag), .wb_wr(wb_wr), .wb_data(wb_data), .br_valid(br_valid),
        .br_instr(br_instr), .br_pc(br_pc), .br_taken(br_taken),
        .br_target(br_target), .br_nullify(br_nullify), .ctl_word(ctl_word)
    );

    function automatic logic [63:0] exp_target(input logic [63:0] pc, input logic [31:0] ins);
        return pc + 64'd4 + {{46{ins[15]}}, ins[15:0], 2'b00};
    endfunction

    function automatic logic exp_cond(input logic [31:0] m, input logic w, input logic [31:0] d);
        return w ? d[23] : m[23];
    endfunction

    function automatic logic [31:0] exp_next(input logic [31:0] m, input logic cv, input logic ok,
                                             input logic f, input logic w, input logic [31:0] d);
        logic [31:0] n;
        n = w ? d : m;
        if (cv && ok) n[23] = f;
        return n;
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, check branch outputs, then the word.
    task automatic cycle(input logic cv, input logic ok, input logic f, input logic w,
                         input logic [31:0] d, input logic bv, input logic [31:0] ins,
                         input logic [63:0] pc, input string tag);
        logic c, tk, nl;
        @(negedge clk);
        cmp_valid = cv; cmp_fmt_ok = ok; cmp_flag = f;
        wb_wr = w; wb_data = d; br_valid = bv; br_instr = ins; br_pc = pc;
        #2;
        c  = exp_cond(model, w, d);
        tk = bv && (c == ins[16]);
        nl = bv && ins[17] && !tk;
        check64({tag, " R6 R5 R9 taken"}, {63'd0, br_taken}, {63'd0, tk});
        check64({tag, " R8 R9 nullify"}, {63'd0, br_nullify}, {63'd0, nl});
        check64({tag, " R7 target"}, br_target, exp_target(pc, ins));
        model = exp_next(model, cv, ok, f, w, d);
        @(posedge clk); #1;
        check64({tag, " R2 R3 R4 word"}, {32'd0, ctl_word}, {32'd0, model});
    endtask

    function automatic logic [31:0] mk_ins(input logic [1:0] kind, input logic [15:0] imm);
        return {14'h1234, kind, imm};
    endfunction

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unsigned s;
        s = $urandom(32'h0BADC0DE);
        rst_n = 1'b0; cmp_valid = 0; cmp_fmt_ok = 0; cmp_flag = 0;
        wb_wr = 0; wb_data = '0; br_valid = 0; br_instr = '0; br_pc = '0;
        model = '0;
        repeat (3) @(posedge clk);
        #1;
        check64("R1 reset word", {32'd0, ctl_word}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R2: set condition, others zero; then all ones background via write.
        cycle(1, 1, 1, 0, 0, 0, 0, 0, "R2 cmp set");
        cycle(0, 0, 0, 1, 32'hFF7F_FFFF, 0, 0, 0, "R4 wb write");
        cycle(1, 1, 1, 0, 0, 0, 0, 0, "R2 cmp set keep others");
        cycle(1, 1, 0, 0, 0, 0, 0, 0, "R2 cmp clear keep others");
        // R3: illegal format compare ignored.
        cycle(1, 0, 1, 0, 0, 0, 0, 0, "R3 illegal cmp");
        // R4: compare and write together.
        cycle(1, 1, 1, 1, 32'h0000_0005, 0, 0, 0, "R4 wb plus cmp");
        // R6 R8: each kind with condition 1 (stored) and 0.
        for (int k = 0; k < 4; k++)
            cycle(0, 0, 0, 0, 0, 1, mk_ins(k[1:0], 16'h0010), 64'h1000, "R6 kind cond1");
        cycle(1, 1, 0, 0, 0, 0, 0, 0, "R2 clear");
        for (int k = 0; k < 4; k++)
            cycle(0, 0, 0, 0, 0, 1, mk_ins(k[1:0], 16'h0010), 64'h1000, "R6 kind cond0");
        // R5: stored 0, in-flight write has bit 23 = 1.
        cycle(0, 0, 0, 1, 32'h0080_0000, 1, mk_ins(2'd1, 16'h0001), 64'h2000, "R5 forward");
        // R5: stored 1 now, in-flight write clears it; likely-true must nullify.
        cycle(0, 0, 0, 1, 32'h0000_0000, 1, mk_ins(2'd3, 16'h0001), 64'h2000, "R5 forward likely");
        // R7: wraparound at both ends.
        cycle(0, 0, 0, 0, 0, 1, mk_ins(2'd0, 16'h0001), 64'hFFFF_FFFF_FFFF_FFFC, "R7 wrap up");
        cycle(0, 0, 0, 0, 0, 1, mk_ins(2'd0, 16'hFFFC), 64'h0000_0000_0000_0004, "R7 wrap down");
        cycle(0, 0, 0, 0, 0, 1, mk_ins(2'd1, 16'h8000), 64'h0000_0001_0000_0000, "R7 min imm");
        // R9: invalid branch strobe.
        cycle(0, 0, 0, 0, 0, 0, mk_ins(2'd2, 16'h0004), 64'h3000, "R9 idle");

        for (int i = 0; i < 600; i++) begin
            logic [63:0] pc;
            pc = {$urandom, $urandom};
            cycle(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                  $urandom, 1'($urandom), $urandom, pc, "random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule